// File: doc/BRIEF.md
# Completion Queue Poster with Phase Tag

This block runs the producer side of one circular completion queue that lives in host memory. Completion requests come in over a valid/ready handshake. Each request carries a command identifier, the identifier of the submission queue it came from, that queue's current head and a 15-bit status code. The requests wait in a small internal FIFO. For each request the block builds a completion entry and works out the slot address from a base address and a power-of-two entry size. It then issues one memory-write request and waits for the transport to acknowledge completion before it starts on the next entry.

The block keeps the producer tail, the consumer head and the phase tag. The phase tag inverts each time the tail wraps, and it travels in bit 0 of the entry's status halfword. From this bit the consumer can tell new entries from stale ones. While the ring is full the block stops posting and the pending requests stay in order in the FIFO. The consumer returns slots by writing a new head value on the doorbell input. When a posting pass ends, the block raises a one-cycle interrupt request, but only if interrupts are enabled for the queue. A queue-initialise pulse brings the ring back to its creation state.

Top module: `cq_poster`

## Requirements
- R1: The ring holds `cfg_size + 1` slots. The tail counts 0, 1, … up to `cfg_size` and then returns to 0.
- R2: After reset, and in the cycle after a one-cycle `q_init` pulse, the tail is 0, the head is 0 and the phase tag is 1. After reset `req_ready` is 1 and `wr_valid` and `irq` are 0. The FIFO and any entry in progress are dropped on `q_init`.
- R3: The phase tag inverts each time the tail goes from `cfg_size` back to 0. Bit 0 of `wr_status` always carries the phase tag that was current when the entry was built.
- R4: `wr_status` equals `{req_sc, phase}`: the status code is in bits 15:1 and the phase tag in bit 0.
- R5: Each entry carries the request's `cid`, `sqid` and `sqhd` values unchanged.
- R6: `wr_addr` equals `cfg_base + tail * 2**cfg_esz_exp`, using the tail value from before that entry advances it.
- R7: The ring is full when (tail + 1) mod (`cfg_size` + 1) equals the head. While it is full, no entry is posted and pending requests are kept. Posting resumes after a head update frees a slot.
- R8: A doorbell whose `hd_value` is larger than `cfg_size` is ignored. A valid doorbell takes effect in the next cycle.
- R9: `irq` is a one-cycle pulse. It follows the `wr_done` cycle of a pass's last entry, which is the point where the FIFO is empty or the ring is full. It occurs only when `cfg_irq_en` is 1.
- R10: `req_ready` is 0 exactly when the FIFO holds `FIFO_DEPTH` requests. Entries are posted in the order the requests were accepted.
- R11: `wr_valid` stays high with a stable payload until `wr_ready`. No further entry is issued before `wr_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_init | input | 1 | Queue-initialise pulse (creation) |
| cfg_size | input | QSZ_W | Ring size minus one |
| cfg_base | input | ADDR_W | Ring base address |
| cfg_esz_exp | input | EXP_W | log2 of the entry size in bytes |
| cfg_irq_en | input | 1 | Interrupt enable for this queue |
| req_valid | input | 1 | Completion request valid |
| req_ready | output | 1 | FIFO can accept a request |
| req_cid | input | 16 | Command identifier |
| req_sqid | input | 16 | Originating submission-queue identifier |
| req_sqhd | input | 16 | Submission-queue head to report |
| req_sc | input | 15 | Status code |
| hd_valid | input | 1 | Consumer head doorbell strobe |
| hd_value | input | QSZ_W | New consumer head |
| wr_valid | output | 1 | Memory-write request valid |
| wr_ready | input | 1 | Memory-write request accepted |
| wr_addr | output | ADDR_W | Slot address of the entry |
| wr_cid | output | 16 | Entry command identifier |
| wr_sqid | output | 16 | Entry submission-queue identifier |
| wr_sqhd | output | 16 | Entry submission-queue head |
| wr_status | output | 16 | Status halfword with the phase tag in bit 0 |
| wr_done | input | 1 | Memory write finished |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench builds the block with `QSZ_W = 4`, `FIFO_DEPTH = 4` and `ADDR_W = 24`. It sweeps ring sizes of 2, 3, 4 and 6 slots and entry-size exponents of 2, 4 and 6. With these small rings, every configuration goes through several tail wraps and phase inversions, and every configuration fills the ring completely. Because the four-deep FIFO backs up behind a full ring, `req_ready` drops within a few requests. Out-of-range doorbells, write-side stalls and interrupt gating are all reached within a few hundred cycles per configuration.

// File: rtl/cqp_pkg.sv
package cqp_pkg;

  typedef struct packed {
    logic [15:0] cid;
    logic [15:0] sqid;
    logic [15:0] sqhd;
    logic [14:0] sc;
  } cqp_req_t;

  typedef enum logic [1:0] {
    CQP_IDLE  = 2'd0,
    CQP_ISSUE = 2'd1,
    CQP_WAIT  = 2'd2
  } cqp_state_e;

  // Status halfword: code above, phase tag in the lowest bit.
  function automatic logic [15:0] cqp_status(input logic [14:0] sc, input logic ph);
    return {sc, ph};
  endfunction

endpackage

// File: rtl/cqp_fifo.sv
module cqp_fifo #(
  parameter int W     = 63,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  input  logic          pop,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          push, take;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign in_ready  = (cnt != CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rptr];
  assign push      = in_valid && in_ready;
  assign take      = pop && out_valid;
  assign count     = cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (take) rptr <= bump(rptr);
      case ({push, take})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/cqp_ring.sv
module cqp_ring #(
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [IW-1:0] size_fld,
  input  logic          adv,
  input  logic          hd_valid,
  input  logic [IW-1:0] hd_value,
  output logic [IW-1:0] tail,
  output logic [IW-1:0] head,
  output logic          phase,
  output logic          full,
  output logic          wrap
);

  // Successor of an index on a ring whose last slot is 'last'.
  function automatic logic [IW-1:0] ring_next(input logic [IW-1:0] idx,
                                              input logic [IW-1:0] last);
    return (idx == last) ? '0 : idx + IW'(1);
  endfunction

  logic hd_ok;

  assign full  = (ring_next(tail, size_fld) == head);
  assign wrap  = adv && (tail == size_fld);
  assign hd_ok = hd_valid && (hd_value <= size_fld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail  <= '0;
      head  <= '0;
      phase <= 1'b1;
    end else if (clr) begin
      tail  <= '0;
      head  <= '0;
      phase <= 1'b1;
    end else begin
      if (adv)   tail  <= ring_next(tail, size_fld);
      if (wrap)  phase <= ~phase;
      if (hd_ok) head  <= hd_value;
    end
  end

endmodule

// File: rtl/cqp_issue.sv
module cqp_issue
  import cqp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IW     = 12,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fifo_valid,
  input  cqp_req_t          fifo_data,
  input  logic              q_full,
  input  logic [IW-1:0]     tail,
  input  logic              phase,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [EXP_W-1:0]  cfg_exp,
  input  logic              cfg_irq_en,
  output logic              post_evt,
  output logic              pass_end,
  output logic              wr_valid,
  input  logic              wr_ready,
  input  logic              wr_done,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_cid,
  output logic [15:0]       wr_sqid,
  output logic [15:0]       wr_sqhd,
  output logic [15:0]       wr_status,
  output logic              irq
);

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IW-1:0]     idx,
                                                  input logic [EXP_W-1:0]  ex);
    return base + (ADDR_W'(idx) << ex);
  endfunction

  cqp_state_e state_q;
  logic       irq_q;

  assign post_evt = (state_q == CQP_IDLE) && fifo_valid && !q_full;
  assign pass_end = (state_q == CQP_WAIT) && wr_done && (!fifo_valid || q_full);
  assign wr_valid = (state_q == CQP_ISSUE);
  assign irq      = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= CQP_IDLE;
      irq_q     <= 1'b0;
      wr_addr   <= '0;
      wr_cid    <= '0;
      wr_sqid   <= '0;
      wr_sqhd   <= '0;
      wr_status <= '0;
    end else if (clr) begin
      state_q <= CQP_IDLE;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= pass_end && cfg_irq_en;
      case (state_q)
        CQP_IDLE: begin
          if (post_evt) begin
            wr_addr   <= slot_addr(cfg_base, tail, cfg_exp);
            wr_status <= cqp_status(fifo_data.sc, phase);
            wr_cid    <= fifo_data.cid;
            wr_sqid   <= fifo_data.sqid;
            wr_sqhd   <= fifo_data.sqhd;
            state_q   <= CQP_ISSUE;
          end
        end
        CQP_ISSUE: if (wr_ready) state_q <= CQP_WAIT;
        CQP_WAIT:  if (wr_done)  state_q <= CQP_IDLE;
        default:   state_q <= CQP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cq_poster.sv
module cq_poster
  import cqp_pkg::*;
#(
  parameter int QSZ_W      = 12,
  parameter int ADDR_W     = 64,
  parameter int EXP_W      = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int REQ_W     = $bits(cqp_req_t),
  localparam int FCW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_init,
  input  logic [QSZ_W-1:0]  cfg_size,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [EXP_W-1:0]  cfg_esz_exp,
  input  logic              cfg_irq_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [15:0]       req_cid,
  input  logic [15:0]       req_sqid,
  input  logic [15:0]       req_sqhd,
  input  logic [14:0]       req_sc,
  input  logic              hd_valid,
  input  logic [QSZ_W-1:0]  hd_value,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_cid,
  output logic [15:0]       wr_sqid,
  output logic [15:0]       wr_sqhd,
  output logic [15:0]       wr_status,
  input  logic              wr_done,
  output logic              irq
);

  cqp_req_t         in_req, head_req;
  logic [REQ_W-1:0] head_bits;
  logic             fifo_valid;
  logic [FCW-1:0]   fifo_cnt;
  logic             post_evt, pass_end;
  logic             q_full, tail_wrap, phase;
  logic [QSZ_W-1:0] tail, head;

  always_comb begin
    in_req.cid  = req_cid;
    in_req.sqid = req_sqid;
    in_req.sqhd = req_sqhd;
    in_req.sc   = req_sc;
  end
  assign head_req = cqp_req_t'(head_bits);

  cqp_fifo #(.W(REQ_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (q_init),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (in_req),
    .out_valid (fifo_valid),
    .out_data  (head_bits),
    .pop       (post_evt),
    .count     (fifo_cnt)
  );

  cqp_ring #(.IW(QSZ_W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (q_init),
    .size_fld (cfg_size),
    .adv      (post_evt),
    .hd_valid (hd_valid),
    .hd_value (hd_value),
    .tail     (tail),
    .head     (head),
    .phase    (phase),
    .full     (q_full),
    .wrap     (tail_wrap)
  );

  cqp_issue #(.ADDR_W(ADDR_W), .IW(QSZ_W), .EXP_W(EXP_W)) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (q_init),
    .fifo_valid (fifo_valid),
    .fifo_data  (head_req),
    .q_full     (q_full),
    .tail       (tail),
    .phase      (phase),
    .cfg_base   (cfg_base),
    .cfg_exp    (cfg_esz_exp),
    .cfg_irq_en (cfg_irq_en),
    .post_evt   (post_evt),
    .pass_end   (pass_end),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_done    (wr_done),
    .wr_addr    (wr_addr),
    .wr_cid     (wr_cid),
    .wr_sqid    (wr_sqid),
    .wr_sqhd    (wr_sqhd),
    .wr_status  (wr_status),
    .irq        (irq)
  );

endmodule

// File: rtl/cqp_checker.sv
module cqp_checker #(
  parameter int IW     = 12,
  parameter int ADDR_W = 64,
  parameter int CW     = 3,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              q_init,
  input logic [IW-1:0]     cfg_size,
  input logic              cfg_irq_en,
  input logic              req_ready,
  input logic [CW-1:0]     fifo_cnt,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_status,
  input logic              wr_done,
  input logic              irq,
  input logic              post_evt,
  input logic              q_full,
  input logic [IW-1:0]     tail,
  input logic [IW-1:0]     head,
  input logic              phase,
  input logic              tail_wrap
);

  a_r1_tail_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    post_evt |-> tail <= cfg_size);

  a_r2_init_state: assert property (@(posedge clk) disable iff (!rst_n)
    q_init |=> (tail == '0) && (head == '0) && phase);

  a_r3_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
    tail_wrap && !q_init |=> phase != $past(phase));

  a_r7_no_post_full: assert property (@(posedge clk) disable iff (!rst_n)
    post_evt |-> !q_full);

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cfg_irq_en);

  a_r9_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wr_done));

  a_r10_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> fifo_cnt == CW'(DEPTH));

  a_r11_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready && !q_init |=> wr_valid && $stable(wr_addr) && $stable(wr_status));

endmodule

bind cq_poster cqp_checker #(
  .IW(QSZ_W), .ADDR_W(ADDR_W), .CW(FCW), .DEPTH(FIFO_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .q_init     (q_init),
  .cfg_size   (cfg_size),
  .cfg_irq_en (cfg_irq_en),
  .req_ready  (req_ready),
  .fifo_cnt   (fifo_cnt),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_status  (wr_status),
  .wr_done    (wr_done),
  .irq        (irq),
  .post_evt   (post_evt),
  .q_full     (q_full),
  .tail       (tail),
  .head       (head),
  .phase      (phase),
  .tail_wrap  (tail_wrap)
);

// File: tb/cq_poster_bench.sv
module cq_poster_bench;

  localparam int CLK_PERIOD = 10;
  localparam int QW = 4;
  localparam int AW = 24;
  localparam int EW = 4;
  localparam int FD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          q_init = 1'b0;
  logic [QW-1:0] cfg_size = '0;
  logic [AW-1:0] cfg_base = '0;
  logic [EW-1:0] cfg_esz_exp = '0;
  logic          cfg_irq_en = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [15:0]   req_cid = '0, req_sqid = '0, req_sqhd = '0;
  logic [14:0]   req_sc = '0;
  logic          hd_valid = 1'b0;
  logic [QW-1:0] hd_value = '0;
  logic          wr_valid;
  logic          wr_ready = 1'b1;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_cid, wr_sqid, wr_sqhd, wr_status;
  logic          wr_done = 1'b0;
  logic          irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  cq_poster #(.QSZ_W(QW), .ADDR_W(AW), .EXP_W(EW), .FIFO_DEPTH(FD)) u_cq_poster (
    .clk(clk), .rst_n(rst_n), .q_init(q_init), .cfg_size(cfg_size),
    .cfg_base(cfg_base), .cfg_esz_exp(cfg_esz_exp), .cfg_irq_en(cfg_irq_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_cid(req_cid),
    .req_sqid(req_sqid), .req_sqhd(req_sqhd), .req_sc(req_sc),
    .hd_valid(hd_valid), .hd_value(hd_value), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_cid(wr_cid), .wr_sqid(wr_sqid),
    .wr_sqhd(wr_sqhd), .wr_status(wr_status), .wr_done(wr_done), .irq(irq)
  );

  int vectors = 0, fails = 0;
  // bench-side ring model
  int m_tail = 0, m_size_fld = 1, m_exp = 0;
  bit m_phase = 1'b1, fresh = 1'b0;
  logic [AW-1:0] m_base = '0;
  int posted = 0, irq_cnt = 0, stall = 0;
  logic [15:0] e_cid [256], e_sqid [256], e_sqhd [256];
  logic [14:0] e_sc [256];
  int e_wr = 0, e_rd = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory-side responder and entry checker
  initial begin : responder
    bit pend = 0, stalled = 0;
    forever begin
      @(negedge clk);
      if (irq) irq_cnt++;
      wr_done = pend;
      pend = 0;
      if (stalled) begin
        chk(wr_valid == 1'b1, "R11 valid held during stall", longint'(wr_valid), 1);
        stalled = 0;
      end
      if (wr_valid) begin
        if (stall > 0) begin
          wr_ready = 1'b0;
          stall--;
          stalled = 1;
        end else begin
          logic [AW-1:0] ea;
          logic [15:0]   es;
          wr_ready = 1'b1;
          ea = m_base + AW'(m_tail * (1 << m_exp));
          es = {e_sc[e_rd % 256], m_phase};
          chk(wr_addr == ea, "R6 slot address", longint'(wr_addr), longint'(ea));
          chk(wr_status == es, "R4 status halfword", longint'(wr_status), longint'(es));
          chk(wr_status[0] == m_phase, "R3 phase bit", longint'(wr_status[0]), longint'(m_phase));
          chk({wr_cid, wr_sqid, wr_sqhd} == {e_cid[e_rd % 256], e_sqid[e_rd % 256], e_sqhd[e_rd % 256]},
              "R5 entry identifiers", longint'({wr_cid, wr_sqid, wr_sqhd}),
              longint'({e_cid[e_rd % 256], e_sqid[e_rd % 256], e_sqhd[e_rd % 256]}));
          if (fresh) begin
            chk(wr_addr == m_base && wr_status[0], "R2 first entry after init",
                longint'(wr_addr), longint'(m_base));
            fresh = 0;
          end
          if (m_tail == m_size_fld) begin
            m_tail = 0;
            m_phase = ~m_phase;
          end else begin
            m_tail++;
          end
          e_rd++;
          posted++;
          pend = 1;
        end
      end
    end
  end

  task automatic push_one();
    @(negedge clk);
    e_cid[e_wr % 256]  = 16'(e_wr * 7 + 3);
    e_sqid[e_wr % 256] = 16'(e_wr % 5 + 1);
    e_sqhd[e_wr % 256] = 16'(e_wr * 3);
    e_sc[e_wr % 256]   = 15'(e_wr * 37 + 1);
    req_cid  = e_cid[e_wr % 256];
    req_sqid = e_sqid[e_wr % 256];
    req_sqhd = e_sqhd[e_wr % 256];
    req_sc   = e_sc[e_wr % 256];
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    e_wr++;
    #1 req_valid = 1'b0;
  endtask

  task automatic doorbell(input int v);
    @(negedge clk);
    hd_valid = 1'b1;
    hd_value = QW'(v);
    @(negedge clk);
    hd_valid = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stimulus
    int sizes [4] = '{1, 2, 3, 5};
    int exps  [3] = '{2, 4, 6};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready after reset", longint'(req_ready), 1);
    chk(wr_valid == 1'b0, "R2 no write after reset", longint'(wr_valid), 0);
    chk(irq == 1'b0, "R2 no irq after reset", longint'(irq), 0);

    foreach (sizes[si]) begin
      foreach (exps[xi]) begin
        int f, k;
        bit en;
        f  = sizes[si];
        en = (exps[xi] != 4);
        k  = f + FD;
        // configure and create the queue in one cycle
        @(negedge clk);
        cfg_size    = QW'(f);
        cfg_esz_exp = EW'(exps[xi]);
        cfg_base    = AW'(24'h010000 + f * 24'h1100 + exps[xi] * 24'h10);
        cfg_irq_en  = en;
        q_init      = 1'b1;
        m_size_fld = f; m_exp = exps[xi]; m_base = cfg_base;
        m_tail = 0; m_phase = 1'b1; fresh = 1'b1;
        @(negedge clk);
        q_init = 1'b0;
        posted = 0; irq_cnt = 0;
        stall = (exps[xi] == 6) ? 3 : 0;

        // R7/R10: fill the ring, then the FIFO behind it
        for (int i = 0; i < k; i++) push_one();
        wait_cycles(30);
        chk(posted == f, "R7 posting stops at full ring", posted, f);
        chk(req_ready == 1'b0, "R10 ready low with FIFO full", longint'(req_ready), 0);

        // R8: out-of-range head is ignored
        doorbell(f + 1);
        wait_cycles(20);
        chk(posted == f, "R8 bad head ignored", posted, f);

        // R7: resume after valid head updates, order kept (R10)
        for (int r = 0; r < 20 && posted < k; r++) begin
          doorbell(m_tail);
          wait_cycles(30);
        end
        chk(posted == k, "R7 resume after head moves", posted, k);
        chk(en ? (irq_cnt >= 1) : (irq_cnt == 0), "R9 irq gating over passes",
            irq_cnt, en ? 1 : 0);

        // R9: a single-entry pass raises exactly one pulse when enabled
        doorbell(m_tail);
        wait_cycles(5);
        irq_cnt = 0;
        push_one();
        wait_cycles(20);
        chk(irq_cnt == (en ? 1 : 0), "R9 one pulse per pass", irq_cnt, en ? 1 : 0);
        chk(posted == k + 1, "R1 single entry posted", posted, k + 1);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule